// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small accumulator processor. Its architectural state is a program counter, a memory address register, a memory data register, a current instruction register, an accumulator, an index register and a two-flag status register (zero and negative). A multi-cycle control machine walks each instruction through a fetch made of separate register transfers. The fetch loads the address register from the program counter, reads memory into the data register while the program counter advances, and copies the data register into the instruction register. The machine then decodes the instruction and resolves its operand in one of four addressing modes before executing it.

The core drives a single-port synchronous memory through an address bus, a write-data bus, a read-data bus and separate read and write strobes. The memory returns read data one cycle after the read strobe and serves one access per cycle. The memory has a fixed latency and never stalls, so the core has no back-pressure input. The read and write strobes work as per-cycle valid signals that the memory must always accept.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, index register and both flags. While reset is held, both strobes and `halted` are low. The first fetch after reset reads address 0.
- R2: Each instruction begins with five cycles: an address-register load cycle, a cycle with the read strobe high and the address bus equal to the program counter, two capture cycles and a decode cycle. The program counter rises by one in the read cycle, so instructions that do not branch are fetched from consecutive addresses.
- R3: An instruction word has the opcode in bits 15:12, the addressing mode in bits 11:10 and the operand field in bits 9:0. The opcodes are 0 no-op, 1 load, 2 store, 3 add, 4 compare, 5 jump, 6 jump-if-zero, 7 load-index and 15 halt. Every other opcode acts as a no-op.
- R4: Mode 0 (immediate) uses the operand field, zero-extended, as the value. It makes no memory access and spends one execute cycle after decode.
- R5: Mode 1 (direct) reads the value from the address given by the operand field. The read strobe is high in the second cycle after decode, and the execute cycle follows two cycles later.
- R6: Mode 2 (indirect) first reads the word at the operand field. Bits 9:0 of that word give the address of a second read, which supplies the value. The two reads are three cycles apart.
- R7: Mode 3 (indexed) reads the value at the operand field plus the index register, modulo 1024.
- R8: A store writes the accumulator at the effective address in a single write-strobe cycle. Immediate mode stores to the operand field as direct mode does, and indirect mode reads the pointer first.
- R9: Add replaces the accumulator with the sum modulo 2^16.
- R10: Compare leaves the accumulator unchanged. It sets the zero flag when the accumulator equals the value, and sets the negative flag from bit 15 of the accumulator minus the value.
- R11: Jump loads the program counter from the operand field. Jump-if-zero does so only when the zero flag is set and otherwise falls through.
- R12: After a halt is decoded, `halted` stays high, neither strobe rises again and the address bus holds the halt instruction's address until reset.
- R13: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 10 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe; `mem_wdata` is written at `mem_addr` at the clock edge |
| mem_wdata | output | 16 | Write data, the accumulator |
| mem_rdata | input | 16 | Read data, valid one cycle after a read strobe |
| halted | output | 1 | High while the core is halted |

## Verification
The hardest cases to reach from the pins are state that only shows up later in the program. The zero flag is one: it can be seen only through a later conditional jump, so the stimulus sets it with a compare just before halting, resets the core, and then places a jump-if-zero that must fall through. The index register is the other: the only way to exercise address wraparound is to load it near the top of the address space and issue an indexed load. The result is then stored so the wrapped address shows on the write-data bus. Indirect accesses use pointer words with non-zero upper bits, which checks that only the low ten bits are used as the address.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W   = 4;
  localparam int MODE_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_STA = 4'h2,
    OP_ADD = 4'h3,
    OP_CMP = 4'h4,
    OP_JMP = 4'h5,
    OP_JZ  = 4'h6,
    OP_LDX = 4'h7,
    OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 2'd0,
    AM_DIR = 2'd1,
    AM_IND = 2'd2,
    AM_IDX = 2'd3
  } amode_e;

  typedef enum logic [3:0] {
    S_FMAR,  // address register <- program counter
    S_FRD,   // read strobe at fetch address, program counter + 1
    S_FMDR,  // data register <- memory
    S_FCIR,  // instruction register <- data register
    S_DEC,   // decode, branch resolution
    S_OMAR,  // address register <- operand address
    S_IRD,   // pointer read
    S_IMDR,  // pointer capture
    S_IMAR,  // address register <- pointer
    S_ORD,   // operand read
    S_OMDR,  // operand capture
    S_EXEC,  // accumulator / index / flags update
    S_WR,    // store
    S_HALT
  } state_e;

  typedef struct packed {
    logic ld_mar_pc;
    logic ld_mar_ea;
    logic ld_mar_mdr;
    logic inc_pc;
    logic ld_mdr_mem;
    logic ld_mdr_imm;
    logic ld_cir;
    logic ld_pc_jump;
    logic exec_en;
  } ctl_t;

  function automatic logic reads_value(opcode_e op);
    return (op == OP_LDA) || (op == OP_ADD) || (op == OP_CMP) || (op == OP_LDX);
  endfunction

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  input  amode_e  mode,
  input  logic    flag_z,
  output state_e  state,
  output ctl_t    ctl,
  output logic    mem_rd,
  output logic    mem_wr,
  output logic    halted
);

  state_e state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FMAR;
    else     state <= state_nx;
  end

  // Next-state selection
  always_comb begin
    state_nx = state;
    case (state)
      S_FMAR: state_nx = S_FRD;
      S_FRD:  state_nx = S_FMDR;
      S_FMDR: state_nx = S_FCIR;
      S_FCIR: state_nx = S_DEC;
      S_DEC: begin
        if (op == OP_HLT)
          state_nx = S_HALT;
        else if (op == OP_STA)
          state_nx = S_OMAR;
        else if (reads_value(op))
          state_nx = (mode == AM_IMM) ? S_EXEC : S_OMAR;
        else
          state_nx = S_FMAR;
      end
      S_OMAR: begin
        if (mode == AM_IND)     state_nx = S_IRD;
        else if (op == OP_STA)  state_nx = S_WR;
        else                    state_nx = S_ORD;
      end
      S_IRD:  state_nx = S_IMDR;
      S_IMDR: state_nx = S_IMAR;
      S_IMAR: state_nx = (op == OP_STA) ? S_WR : S_ORD;
      S_ORD:  state_nx = S_OMDR;
      S_OMDR: state_nx = S_EXEC;
      S_EXEC: state_nx = S_FMAR;
      S_WR:   state_nx = S_FMAR;
      S_HALT: state_nx = S_HALT;
      default: state_nx = S_FMAR;
    endcase
  end

  // Per-state register-transfer strobes
  always_comb begin
    ctl    = '0;
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    halted = 1'b0;
    case (state)
      S_FMAR: ctl.ld_mar_pc = 1'b1;
      S_FRD: begin
        mem_rd     = 1'b1;
        ctl.inc_pc = 1'b1;
      end
      S_FMDR: ctl.ld_mdr_mem = 1'b1;
      S_FCIR: ctl.ld_cir     = 1'b1;
      S_DEC: begin
        ctl.ld_mdr_imm = reads_value(op) && (mode == AM_IMM);
        ctl.ld_pc_jump = (op == OP_JMP) || ((op == OP_JZ) && flag_z);
      end
      S_OMAR: ctl.ld_mar_ea  = 1'b1;
      S_IRD:  mem_rd         = 1'b1;
      S_IMDR: ctl.ld_mdr_mem = 1'b1;
      S_IMAR: ctl.ld_mar_mdr = 1'b1;
      S_ORD:  mem_rd         = 1'b1;
      S_OMDR: ctl.ld_mdr_mem = 1'b1;
      S_EXEC: ctl.exec_en    = 1'b1;
      S_WR:   mem_wr         = 1'b1;
      S_HALT: halted         = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_agen.sv
module acc_agen
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  amode_e            mode,
  input  logic [ADDR_W-1:0] field,
  input  logic [ADDR_W-1:0] ix_lo,
  output logic [ADDR_W-1:0] ea
);

  // Indexed mode offsets by the index register; the sum wraps in the
  // address space. Direct, indirect (first hop) and immediate stores use
  // the field as-is.
  always_comb begin
    if (mode == AM_IDX) ea = field + ix_lo;
    else                ea = field;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] acc_nx,
  output logic [DATA_W-1:0] ix_nx,
  output logic              z_nx,
  output logic              n_nx,
  output logic              wr_acc,
  output logic              wr_ix,
  output logic              wr_sr
);

  logic [DATA_W-1:0] diff;

  always_comb begin
    diff   = acc - val;
    z_nx   = (diff == '0);
    n_nx   = diff[DATA_W-1];
    ix_nx  = val;
    acc_nx = acc;
    wr_acc = 1'b0;
    wr_ix  = 1'b0;
    wr_sr  = 1'b0;
    case (op)
      OP_LDA: begin
        acc_nx = val;
        wr_acc = 1'b1;
      end
      OP_ADD: begin
        acc_nx = acc + val;
        wr_acc = 1'b1;
      end
      OP_CMP: wr_sr = 1'b1;
      OP_LDX: wr_ix = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] acc_nx,
  input  logic [DATA_W-1:0] ix_nx,
  input  logic              z_nx,
  input  logic              n_nx,
  input  logic              wr_acc,
  input  logic              wr_ix,
  input  logic              wr_sr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] cir,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ix,
  output logic              flag_z,
  output logic              flag_n
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] field;
  assign field = cir[ADDR_W-1:0];

  // Program counter: advance during fetch read, reload on taken branch
  always_ff @(posedge clk) begin
    if (rst)                 pc <= '0;
    else if (ctl.inc_pc)     pc <= pc + ADDR_W'(1);
    else if (ctl.ld_pc_jump) pc <= field;
  end

  // Memory address register, three sources
  always_ff @(posedge clk) begin
    if (rst)                 mar <= '0;
    else if (ctl.ld_mar_pc)  mar <= pc;
    else if (ctl.ld_mar_ea)  mar <= ea;
    else if (ctl.ld_mar_mdr) mar <= mdr[ADDR_W-1:0];
  end

  // Memory data register: memory word or zero-extended immediate
  always_ff @(posedge clk) begin
    if (rst)                 mdr <= '0;
    else if (ctl.ld_mdr_mem) mdr <= rdata;
    else if (ctl.ld_mdr_imm) mdr <= {{PAD_W{1'b0}}, field};
  end

  always_ff @(posedge clk) begin
    if (rst)             cir <= '0;
    else if (ctl.ld_cir) cir <= mdr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      ix     <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else if (ctl.exec_en) begin
      if (wr_acc) acc <= acc_nx;
      if (wr_ix)  ix  <= ix_nx;
      if (wr_sr) begin
        flag_z <= z_nx;
        flag_n <= n_nx;
      end
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int  DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W - MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  state_e            state;
  ctl_t              ctl;
  opcode_e           op;
  amode_e            mode;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] ea;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] cir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] ix_q;
  logic              z_q;
  logic              n_q;

  logic [DATA_W-1:0] acc_nx;
  logic [DATA_W-1:0] ix_nx;
  logic              z_nx;
  logic              n_nx;
  logic              wr_acc;
  logic              wr_ix;
  logic              wr_sr;

  // Instruction word split: opcode | mode | operand field
  assign op    = opcode_e'(cir_q[DATA_W-1 -: OP_W]);
  assign mode  = amode_e'(cir_q[ADDR_W +: MODE_W]);
  assign field = cir_q[ADDR_W-1:0];

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .mode   (mode),
    .flag_z (z_q),
    .state  (state),
    .ctl    (ctl),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
  );

  acc_agen #(.ADDR_W(ADDR_W)) u_agen (
    .mode  (mode),
    .field (field),
    .ix_lo (ix_q[ADDR_W-1:0]),
    .ea    (ea)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .acc    (acc_q),
    .val    (mdr_q),
    .acc_nx (acc_nx),
    .ix_nx  (ix_nx),
    .z_nx   (z_nx),
    .n_nx   (n_nx),
    .wr_acc (wr_acc),
    .wr_ix  (wr_ix),
    .wr_sr  (wr_sr)
  );

  acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .rdata  (mem_rdata),
    .ea     (ea),
    .acc_nx (acc_nx),
    .ix_nx  (ix_nx),
    .z_nx   (z_nx),
    .n_nx   (n_nx),
    .wr_acc (wr_acc),
    .wr_ix  (wr_ix),
    .wr_sr  (wr_sr),
    .pc     (pc_q),
    .mar    (mar_q),
    .mdr    (mdr_q),
    .cir    (cir_q),
    .acc    (acc_q),
    .ix     (ix_q),
    .flag_z (z_q),
    .flag_n (n_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input state_e            state,
  input opcode_e           op,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] ix,
  input logic [DATA_W-1:0] mdr,
  input logic              z,
  input logic              n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && acc == '0 && ix == '0 && !z && !n));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FRD) |-> (mem_rd && mem_addr == pc));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FRD) |=> (pc == $past(pc) + ADDR_W'(1)));

  p_cmp_keep_acc_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_CMP) |=> $stable(acc));

  p_cmp_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_CMP) |=> (z == ($past(acc) == $past(mdr))));

  p_jz_fallthru_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && op == OP_JZ && !z) |=> $stable(pc));

  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mem_addr) && $stable(acc) && $stable(pc)));

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  p_one_access_r13: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state    (state),
  .op       (op),
  .pc       (pc_q),
  .acc      (acc_q),
  .ix       (ix_q),
  .mdr      (mdr_q),
  .z        (z_q),
  .n        (n_q),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .halted   (halted)
);

// File: tb/test_acc_core.sv
module test_acc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        halted;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  acc_core i_acc_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // Bus-side memory: one access per cycle, one cycle read latency
  logic [15:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // Reference model state
  int  mmem [0:1023];
  int  m_pc, m_acc, m_ix, m_hadr;
  bit  m_z, m_halt;

  typedef struct {
    bit    rd;
    bit    wr;
    bit    hlt;
    int    addr;
    int    wdata;
    string req;
  } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_e(bit rd, bit wr, bit hlt, int addr, int wdata, string req);
    exp_t e;
    e.rd = rd; e.wr = wr; e.hlt = hlt; e.addr = addr; e.wdata = wdata; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(string req);
    push_e(0, 0, 0, 0, 0, req);
  endtask

  function automatic int enc(int op, int md, int f);
    return (op << 12) | (md << 10) | (f & 1023);
  endfunction

  task automatic put(int a, int v);
    mem[a]  = 16'(v);
    mmem[a] = v & 65535;
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 1024; a++) put(a, 0);
  endtask

  task automatic model_reset();
    m_pc = 0; m_acc = 0; m_ix = 0; m_z = 0; m_halt = 0; m_hadr = 0;
    q.delete();
  endtask

  // Behavioural instruction step: emits the per-cycle bus expectations
  task automatic model_step();
    int ins, op, md, f, ea, val, d;
    string tg;
    if (m_halt) begin
      push_e(0, 0, 1, m_hadr, 0, "R12");
      return;
    end
    ins = mmem[m_pc];
    idle("R2");
    push_e(1, 0, 0, m_pc, 0, "R2");
    idle("R2"); idle("R2"); idle("R2");
    m_hadr = m_pc;
    m_pc = (m_pc + 1) % 1024;
    op = (ins >> 12) & 15;
    md = (ins >> 10) & 3;
    f  = ins & 1023;
    case (op)
      15: m_halt = 1;
      5:  m_pc = f;
      6:  if (m_z) m_pc = f;
      2: begin
        ea = (md == 3) ? (f + m_ix) % 1024 : f;
        idle("R8");
        if (md == 2) begin
          push_e(1, 0, 0, f, 0, "R6");
          idle("R6"); idle("R6");
          ea = mmem[f] & 1023;
        end
        push_e(0, 1, 0, ea, m_acc, "R8");
        mmem[ea] = m_acc;
      end
      1, 3, 4, 7: begin
        if (md == 0) begin
          val = f;
          idle("R4");
        end else begin
          tg = (md == 1) ? "R5" : (md == 2) ? "R6" : "R7";
          idle(tg);
          if (md == 2) begin
            push_e(1, 0, 0, f, 0, "R6");
            idle("R6"); idle("R6");
            ea = mmem[f] & 1023;
          end else if (md == 3) ea = (f + m_ix) % 1024;
          else ea = f;
          push_e(1, 0, 0, ea, 0, tg);
          idle(tg); idle(tg);
          val = mmem[ea];
        end
        case (op)
          1: m_acc = val;
          3: m_acc = (m_acc + val) & 65535;
          4: begin
            d   = (m_acc - val) & 65535;
            m_z = (d == 0);
          end
          default: m_ix = val;
        endcase
      end
      default: ;
    endcase
  endtask

  // Compare the bus on every cycle until six halted cycles have passed
  task automatic run_prog(int max_cyc);
    int hcount = 0;
    for (int c = 0; c < max_cyc; c++) begin
      exp_t e;
      if (q.size() == 0) model_step();
      e = q.pop_front();
      chk(halted == e.hlt, e.req, "halted", int'(halted), int'(e.hlt));
      chk(mem_rd == e.rd, e.req, "mem_rd", int'(mem_rd), int'(e.rd));
      chk(mem_wr == e.wr, e.req, "mem_wr", int'(mem_wr), int'(e.wr));
      if (e.rd || e.wr || e.hlt)
        chk(int'(mem_addr) == e.addr, e.req, "mem_addr", int'(mem_addr), e.addr);
      if (e.wr)
        chk(int'(mem_wdata) == e.wdata, e.req, "mem_wdata", int'(mem_wdata), e.wdata);
      chk(!(mem_rd && mem_wr), "R13", "one access", int'(mem_rd && mem_wr), 0);
      if (e.hlt) hcount++;
      if (hcount == 6) break;
      @(negedge clk);
    end
    chk(hcount == 6, "R12", "halt reached", hcount, 6);
    q.delete();
  endtask

  task automatic load_prog_a();
    clear_mem();
    put(0,  enc(1, 0, 5));     // load #5
    put(1,  enc(3, 1, 100));   // add [100] -> wraps (R9)
    put(2,  enc(2, 1, 200));   // store [200]
    put(3,  enc(7, 0, 2));     // IX = 2
    put(4,  enc(1, 3, 100));   // load [100+IX]
    put(5,  enc(2, 3, 300));   // store [300+IX]
    put(6,  enc(1, 2, 110));   // load [[110]]
    put(7,  enc(2, 2, 111));   // store [[111]]
    put(8,  enc(4, 0, 9));     // compare #9 -> Z
    put(9,  enc(6, 0, 12));    // jz 12 (taken)
    put(10, enc(2, 1, 500));   // skipped
    put(11, enc(15, 0, 0));    // skipped
    put(12, enc(4, 0, 20));    // compare #20 -> not zero, negative
    put(13, enc(6, 0, 10));    // jz 10 (not taken)
    put(14, enc(2, 0, 250));   // immediate store acts as direct
    put(15, enc(5, 0, 20));    // jmp 20
    put(20, enc(1, 1, 200));
    put(21, enc(3, 2, 111));
    put(22, enc(2, 1, 201));
    put(23, enc(0, 0, 0));     // no-op
    put(24, enc(9, 1, 7));     // undefined opcode -> no-op
    put(25, enc(4, 0, 12));    // compare equal, Z set before halt
    put(26, enc(15, 0, 0));
    put(100, 16'hFFFE);
    put(102, 7);
    put(110, 16'h5000 | 120);  // pointer with upper bits set
    put(111, 16'hA000 | 400);
    put(120, 9);
  endtask

  task automatic load_prog_b();
    clear_mem();
    put(0,  enc(2, 1, 62));    // store reset ACC
    put(1,  enc(6, 0, 11));    // jz must fall through after reset
    put(2,  enc(7, 1, 50));    // IX = 1023
    put(3,  enc(1, 3, 4));     // load [(4+1023) mod 1024] = [3]
    put(4,  enc(2, 1, 60));
    put(5,  enc(1, 0, 0));
    put(6,  enc(3, 0, 1));     // loop: add #1
    put(7,  enc(4, 0, 3));
    put(8,  enc(6, 0, 10));
    put(9,  enc(5, 0, 6));
    put(10, enc(2, 1, 61));
    put(11, enc(15, 0, 0));
    put(50, 16'h03FF);
  endtask

  initial begin
    rst = 1'b1;
    load_prog_a();
    model_reset();
    repeat (3) @(negedge clk);
    chk(!mem_rd, "R1", "mem_rd in reset", int'(mem_rd), 0);
    chk(!mem_wr, "R1", "mem_wr in reset", int'(mem_wr), 0);
    chk(!halted, "R1", "halted in reset", int'(halted), 0);
    rst = 1'b0;
    run_prog(2000);
    chk(mem[200] == 16'd3,  "R9",  "sum wrap",       int'(mem[200]), 3);
    chk(mem[302] == 16'd7,  "R7",  "indexed store",  int'(mem[302]), 7);
    chk(mem[400] == 16'd9,  "R6",  "indirect store", int'(mem[400]), 9);
    chk(mem[250] == 16'd9,  "R8",  "imm store",      int'(mem[250]), 9);
    chk(mem[201] == 16'd12, "R6",  "indirect add",   int'(mem[201]), 12);
    chk(mem[500] == 16'd0,  "R11", "skipped store",  int'(mem[500]), 0);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!halted, "R1", "halted cleared", int'(halted), 0);
    chk(!mem_rd && !mem_wr, "R1", "bus idle in reset", int'(mem_rd || mem_wr), 0);
    load_prog_b();
    model_reset();
    rst = 1'b0;
    run_prog(2000);
    chk(mem[62] == 16'd0,    "R1",  "acc after reset", int'(mem[62]), 0);
    chk(mem[60] == 16'h1C04, "R7",  "index wrap",      int'(mem[60]), 'h1C04);
    chk(mem[61] == 16'd3,    "R11", "loop count",      int'(mem[61]), 3);
    chk(mem[11] == 16'hF000, "R3",  "program intact",  int'(mem[11]), 'hF000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule